// File: doc/BRIEF.md
# Class-Routed Micro-Op Dispatch Scheduler

This block holds a window of waiting micro-ops and, every cycle, chooses which of them go to five execution ports. Each entry records the op's class, whether its operands are ready, and where it stands in allocation order. Up to three new ops are written into free slots per cycle through separate allocation lanes. An outside wakeup vector marks entries ready once their operands arrive. Each execution port reports through a free flag whether it can take a new op this cycle.

Routing depends on the class. Multiply, divide, shift/rotate and floating-point ops can use only port 0. Branches can use only port 1. Loads can use only port 2. Store address generation can use only port 3, and store data can use only port 4. Plain move/arithmetic/logic ops can use either port 0 or port 1. Port 0 is filled first. Port 1 then takes the oldest remaining candidate, which may be a branch or a plain op that port 0 did not take.

When several ready ops contend for a port, the oldest one wins. A stalled old entry never holds back a younger ready entry. Ops chosen in a cycle leave the window in that same cycle, and their slots can be allocated again from the next cycle on.

Top module: `dispatch_sched`

## Requirements
- R1: While the internal reset is active, `issue_vld_o` and `alloc_gnt_o` are all zero. Reset is asserted asynchronously and released two clock edges after `rst_n` rises. After reset the window is empty.
- R2: Each allocation lane k with `alloc_vld_i[k]=1` takes the lowest-numbered free slot that no lower-numbered lane took in the same cycle. The lane reports that slot on `alloc_slot_o[k*IW +: IW]` and raises `alloc_gnt_o[k]`. If no free slot remains, the grant is 0. A granted slot is occupied from the next cycle on.
- R3: Only an occupied entry with its ready flag set may issue. The flag is loaded from `alloc_rdy_i` when the entry is allocated. `wake_i[i]=1` sets the flag of occupied slot i from the next cycle on. A not-ready entry never prevents a younger ready entry from issuing.
- R4: The class is a 4-bit code. The port set for each code is:
  - 0 (plain ALU): ports 0 and 1.
  - 1 (multiply), 2 (divide), 3 (shift/rotate), 4 (floating point): port 0.
  - 5 (branch): port 1.
  - 6 (load): port 2.
  - 7 (store address): port 3.
  - 8 (store data): port 4.
  - 9 to 15: no port; such an entry never issues.
- R5: Port 0 issues the oldest eligible entry among codes 0 to 4. Port 1 issues the oldest eligible entry among code 5 and those code-0 entries not issued on port 0 in the same cycle.
- R6: Age is allocation order. An entry allocated in an earlier cycle is older. Within one cycle, a lower lane number is older. Among the candidates for any port, the oldest is chosen.
- R7: When `port_free_i[p]=0`, port p issues nothing. In that case a code-0 op that would have taken port 0 is considered for port 1.
- R8: `release_o` has bit i set exactly when slot i issues on some port this cycle. The slot is empty in the next cycle, and it cannot be granted to a lane in the cycle of its release.
- R9: Each port issues at most one entry per cycle, so up to five entries issue per cycle. No entry issues on two ports. `issue_idx_o[p*IW +: IW]` gives the slot number issued on port p.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| alloc_vld_i | input | N_LANE | Allocation request per lane |
| alloc_cls_i | input | N_LANE*4 | Class code per lane |
| alloc_rdy_i | input | N_LANE | Operands already ready at allocation, per lane |
| alloc_gnt_o | output | N_LANE | Lane accepted into a slot |
| alloc_slot_o | output | N_LANE*IW | Slot number given to each lane |
| wake_i | input | N_ENTRY | Per-slot operand-ready strobe |
| port_free_i | input | 5 | Execution port can accept an op this cycle |
| issue_vld_o | output | 5 | Port issues an op this cycle |
| issue_idx_o | output | 5*IW | Slot number issued per port |
| release_o | output | N_ENTRY | Slots leaving the window this cycle |

## Verification
The assertions assume that `rst_n` is pulled low before the first rising clock edge. They also assume that the inputs only change between edges, so the issue outputs, which follow from state and `port_free_i`, are stable when sampled. No assumption is made about class codes: unknown codes are legal inputs and simply stay in the window. Because such entries never leave, the stimulus resets the block before every exhaustive class/port-mask scenario and every fifty cycles of the random phase. This keeps a clogged window from hiding the ordering and routing behaviour.

// File: rtl/sched_pkg.sv
package sched_pkg;

  localparam int NPORT = 5;
  localparam int CLS_W = 4;

  localparam logic [CLS_W-1:0] CLS_ALU = 4'd0;
  localparam logic [CLS_W-1:0] CLS_MUL = 4'd1;
  localparam logic [CLS_W-1:0] CLS_DIV = 4'd2;
  localparam logic [CLS_W-1:0] CLS_SHF = 4'd3;
  localparam logic [CLS_W-1:0] CLS_FPU = 4'd4;
  localparam logic [CLS_W-1:0] CLS_BRN = 4'd5;
  localparam logic [CLS_W-1:0] CLS_LDA = 4'd6;
  localparam logic [CLS_W-1:0] CLS_STA = 4'd7;
  localparam logic [CLS_W-1:0] CLS_STD = 4'd8;

  // Bit p of the result is set when the class may run on port p.
  function automatic logic [NPORT-1:0] cls_ports(input logic [CLS_W-1:0] c);
    logic [NPORT-1:0] m;
    m = '0;
    case (c)
      CLS_ALU: m = 5'b00011;
      CLS_MUL, CLS_DIV, CLS_SHF, CLS_FPU: m = 5'b00001;
      CLS_BRN: m = 5'b00010;
      CLS_LDA: m = 5'b00100;
      CLS_STA: m = 5'b01000;
      CLS_STD: m = 5'b10000;
      default: m = '0;
    endcase
    return m;
  endfunction

endpackage

// File: rtl/rst_sync.sv
module rst_sync #(
  parameter int STAGES = 2
) (
  input  logic clk,
  input  logic rst_n_i,
  output logic rst_n_o
);

  logic [STAGES-1:0] sync_q;

  always_ff @(posedge clk or negedge rst_n_i) begin
    if (!rst_n_i) sync_q <= '0;
    else          sync_q <= {sync_q[STAGES-2:0], 1'b1};
  end

  assign rst_n_o = sync_q[STAGES-1];

endmodule

// File: rtl/alloc_lanes.sv
module alloc_lanes #(
  parameter int N_ENTRY = 40,
  parameter int N_LANE  = 3,
  localparam int IW     = $clog2(N_ENTRY)
) (
  input  logic [N_ENTRY-1:0]        free_i,
  input  logic [N_LANE-1:0]         req_i,
  output logic [N_LANE-1:0]         gnt_o,
  output logic [N_LANE*N_ENTRY-1:0] oh_o,
  output logic [N_LANE*IW-1:0]      idx_o
);

  always_comb begin
    logic [N_ENTRY-1:0] left;
    logic               found;
    left  = free_i;
    oh_o  = '0;
    gnt_o = '0;
    idx_o = '0;
    for (int k = 0; k < N_LANE; k++) begin
      found = 1'b0;
      for (int i = 0; i < N_ENTRY; i++) begin
        if (req_i[k] && !found && left[i]) begin
          found                  = 1'b1;
          oh_o[k*N_ENTRY + i]    = 1'b1;
          idx_o[k*IW +: IW]      = IW'(i);
        end
      end
      gnt_o[k] = found;
      left     = left & ~oh_o[k*N_ENTRY +: N_ENTRY];
    end
  end

endmodule

// File: rtl/age_matrix.sv
module age_matrix #(
  parameter int N_ENTRY = 40,
  parameter int N_LANE  = 3
) (
  input  logic                        clk,
  input  logic [N_LANE*N_ENTRY-1:0]   lane_oh_i,
  output logic [N_ENTRY*N_ENTRY-1:0]  older_o
);

  logic [N_ENTRY-1:0] newbie;
  logic [N_ENTRY-1:0] after_lane [N_LANE];
  logic               upd_en;

  always_comb begin
    newbie = '0;
    for (int k = 0; k < N_LANE; k++) begin
      newbie        = newbie | lane_oh_i[k*N_ENTRY +: N_ENTRY];
      after_lane[k] = '0;
      for (int m = k + 1; m < N_LANE; m++) begin
        after_lane[k] = after_lane[k] | lane_oh_i[m*N_ENTRY +: N_ENTRY];
      end
    end
  end

  assign upd_en = |newbie;

  // Row r, bit j set: entry r is older than entry j.
  for (genvar r = 0; r < N_ENTRY; r++) begin : g_row
    logic [N_ENTRY-1:0] row_q;
    logic [N_ENTRY-1:0] row_d;

    always_comb begin
      row_d = row_q | newbie;
      for (int k = 0; k < N_LANE; k++) begin
        if (lane_oh_i[k*N_ENTRY + r]) row_d = after_lane[k];
      end
    end

    always_ff @(posedge clk) begin
      if (upd_en) row_q <= row_d;
    end

    assign older_o[r*N_ENTRY +: N_ENTRY] = row_q;
  end

endmodule

// File: rtl/oldest_select.sv
module oldest_select #(
  parameter int N_ENTRY = 40,
  localparam int IW     = $clog2(N_ENTRY)
) (
  input  logic [N_ENTRY-1:0]         cand_i,
  input  logic [N_ENTRY*N_ENTRY-1:0] older_i,
  output logic                       hit_o,
  output logic [N_ENTRY-1:0]         oh_o,
  output logic [IW-1:0]              idx_o
);

  always_comb begin
    for (int i = 0; i < N_ENTRY; i++) begin
      oh_o[i] = cand_i[i];
      for (int j = 0; j < N_ENTRY; j++) begin
        if (j != i && cand_i[j] && !older_i[i*N_ENTRY + j]) oh_o[i] = 1'b0;
      end
    end
  end

  always_comb begin
    idx_o = '0;
    for (int i = 0; i < N_ENTRY; i++) begin
      if (oh_o[i]) idx_o = idx_o | IW'(i);
    end
  end

  assign hit_o = |oh_o;

endmodule

// File: rtl/dispatch_sched.sv
module dispatch_sched
  import sched_pkg::*;
#(
  parameter int N_ENTRY = 40,
  parameter int N_LANE  = 3,
  localparam int IW     = $clog2(N_ENTRY)
) (
  input  logic                    clk,
  input  logic                    rst_n,
  input  logic [N_LANE-1:0]       alloc_vld_i,
  input  logic [N_LANE*CLS_W-1:0] alloc_cls_i,
  input  logic [N_LANE-1:0]       alloc_rdy_i,
  output logic [N_LANE-1:0]       alloc_gnt_o,
  output logic [N_LANE*IW-1:0]    alloc_slot_o,
  input  logic [N_ENTRY-1:0]      wake_i,
  input  logic [NPORT-1:0]        port_free_i,
  output logic [NPORT-1:0]        issue_vld_o,
  output logic [NPORT*IW-1:0]     issue_idx_o,
  output logic [N_ENTRY-1:0]      release_o
);

  logic srst_n;

  rst_sync #(.STAGES(2)) u_rst (
    .clk     (clk),
    .rst_n_i (rst_n),
    .rst_n_o (srst_n)
  );

  // Window state
  logic [N_ENTRY-1:0] valid_q, valid_d;
  logic [N_ENTRY-1:0] ready_q, ready_d;
  logic [CLS_W-1:0]   cls_q [N_ENTRY];
  logic [CLS_W-1:0]   cls_d [N_ENTRY];
  logic               ready_en;

  // Allocation
  logic [N_LANE-1:0]         lane_req;
  logic [N_LANE*N_ENTRY-1:0] lane_oh;
  logic [N_ENTRY-1:0]        ent_new;
  logic [N_ENTRY-1:0]        free_slots;

  assign lane_req   = alloc_vld_i & {N_LANE{srst_n}};
  assign free_slots = ~valid_q;

  alloc_lanes #(.N_ENTRY(N_ENTRY), .N_LANE(N_LANE)) u_alloc (
    .free_i (free_slots),
    .req_i  (lane_req),
    .gnt_o  (alloc_gnt_o),
    .oh_o   (lane_oh),
    .idx_o  (alloc_slot_o)
  );

  always_comb begin
    ent_new = '0;
    for (int k = 0; k < N_LANE; k++) ent_new = ent_new | lane_oh[k*N_ENTRY +: N_ENTRY];
  end

  // Relative age
  logic [N_ENTRY*N_ENTRY-1:0] older;

  age_matrix #(.N_ENTRY(N_ENTRY), .N_LANE(N_LANE)) u_age (
    .clk       (clk),
    .lane_oh_i (lane_oh),
    .older_o   (older)
  );

  // Per-entry port capability
  logic [NPORT-1:0]                cap [N_ENTRY];
  logic [NPORT-1:0][N_ENTRY-1:0]   cand_raw;

  for (genvar i = 0; i < N_ENTRY; i++) begin : g_cap
    assign cap[i] = cls_ports(cls_q[i]) & {NPORT{valid_q[i] & ready_q[i]}};
  end

  always_comb begin
    for (int p = 0; p < NPORT; p++) begin
      for (int i = 0; i < N_ENTRY; i++) begin
        cand_raw[p][i] = cap[i][p] & port_free_i[p];
      end
    end
  end

  // Port 0 picks first; its winner is withheld from port 1.
  logic               hit0;
  logic [N_ENTRY-1:0] sel0_oh;
  logic [IW-1:0]      idx0;

  oldest_select #(.N_ENTRY(N_ENTRY)) u_sel_p0 (
    .cand_i  (cand_raw[0]),
    .older_i (older),
    .hit_o   (hit0),
    .oh_o    (sel0_oh),
    .idx_o   (idx0)
  );

  logic [NPORT-1:1]              hit_hi;
  logic [N_ENTRY-1:0]            sel_hi [NPORT];
  logic [NPORT-1:1][IW-1:0]      idx_hi;

  assign sel_hi[0] = '0;

  for (genvar p = 1; p < NPORT; p++) begin : g_port
    logic [N_ENTRY-1:0] cand_p;
    if (p == 1) begin : g_flex
      assign cand_p = cand_raw[p] & ~sel0_oh;
    end else begin : g_fixed
      assign cand_p = cand_raw[p];
    end

    oldest_select #(.N_ENTRY(N_ENTRY)) u_sel (
      .cand_i  (cand_p),
      .older_i (older),
      .hit_o   (hit_hi[p]),
      .oh_o    (sel_hi[p]),
      .idx_o   (idx_hi[p])
    );
  end

  assign issue_vld_o = {hit_hi, hit0};
  assign issue_idx_o = {idx_hi, idx0};

  always_comb begin
    release_o = sel0_oh;
    for (int p = 1; p < NPORT; p++) release_o = release_o | sel_hi[p];
  end

  // Next state
  always_comb begin
    valid_d = (valid_q & ~release_o) | ent_new;
    ready_d = ready_q | (wake_i & valid_q);
    for (int i = 0; i < N_ENTRY; i++) cls_d[i] = cls_q[i];
    for (int k = 0; k < N_LANE; k++) begin
      for (int i = 0; i < N_ENTRY; i++) begin
        if (lane_oh[k*N_ENTRY + i]) begin
          ready_d[i] = alloc_rdy_i[k];
          cls_d[i]   = alloc_cls_i[k*CLS_W +: CLS_W];
        end
      end
    end
  end

  assign ready_en = (|ent_new) | (|(wake_i & valid_q));

  // Registers
  always_ff @(posedge clk or negedge srst_n) begin
    if (!srst_n) valid_q <= '0;
    else         valid_q <= valid_d;
  end

  always_ff @(posedge clk) begin
    if (ready_en) ready_q <= ready_d;
  end

  always_ff @(posedge clk) begin
    for (int i = 0; i < N_ENTRY; i++) begin
      if (ent_new[i]) cls_q[i] <= cls_d[i];
    end
  end

endmodule

// File: rtl/sched_chk.sv
module sched_chk
  import sched_pkg::*;
#(
  parameter int N_ENTRY = 40,
  parameter int N_LANE  = 3,
  localparam int IW     = $clog2(N_ENTRY)
) (
  input logic                 clk,
  input logic                 srst_n,
  input logic [N_ENTRY-1:0]   valid_q,
  input logic [N_ENTRY-1:0]   ready_q,
  input logic [N_LANE-1:0]    alloc_vld_i,
  input logic [N_LANE-1:0]    alloc_gnt_o,
  input logic [N_LANE*IW-1:0] alloc_slot_o,
  input logic [NPORT-1:0]     port_free_i,
  input logic [NPORT-1:0]     issue_vld_o,
  input logic [NPORT*IW-1:0]  issue_idx_o,
  input logic [N_ENTRY-1:0]   release_o
);

  // R1
  quiet_in_reset_chk: assert property (@(posedge clk)
    !srst_n |-> (issue_vld_o == '0 && alloc_gnt_o == '0));

  // R7
  busy_port_idle_chk: assert property (@(posedge clk) disable iff (!srst_n)
    (issue_vld_o & ~port_free_i) == '0);

  // R9
  flex_ports_distinct_chk: assert property (@(posedge clk) disable iff (!srst_n)
    (issue_vld_o[0] && issue_vld_o[1]) |-> (issue_idx_o[0 +: IW] != issue_idx_o[IW +: IW]));

  // R8
  release_matches_issue_chk: assert property (@(posedge clk) disable iff (!srst_n)
    $countones(release_o) == $countones(issue_vld_o));

  // R8
  released_slot_empty_chk: assert property (@(posedge clk) disable iff (!srst_n)
    (|release_o) |=> ((valid_q & $past(release_o)) == '0));

  // R2
  grant_needs_request_chk: assert property (@(posedge clk) disable iff (!srst_n)
    (alloc_gnt_o & ~alloc_vld_i) == '0);

  for (genvar p = 0; p < NPORT; p++) begin : g_port_chk
    // R3
    issue_ready_entry_chk: assert property (@(posedge clk) disable iff (!srst_n)
      issue_vld_o[p] |-> (valid_q[issue_idx_o[p*IW +: IW]] && ready_q[issue_idx_o[p*IW +: IW]]));
  end

  for (genvar k = 0; k < N_LANE; k++) begin : g_lane_chk
    // R2
    granted_slot_filled_chk: assert property (@(posedge clk) disable iff (!srst_n)
      alloc_gnt_o[k] |=> valid_q[$past(alloc_slot_o[k*IW +: IW])]);
  end

endmodule

bind dispatch_sched sched_chk #(.N_ENTRY(N_ENTRY), .N_LANE(N_LANE)) u_chk (
  .clk          (clk),
  .srst_n       (srst_n),
  .valid_q      (valid_q),
  .ready_q      (ready_q),
  .alloc_vld_i  (alloc_vld_i),
  .alloc_gnt_o  (alloc_gnt_o),
  .alloc_slot_o (alloc_slot_o),
  .port_free_i  (port_free_i),
  .issue_vld_o  (issue_vld_o),
  .issue_idx_o  (issue_idx_o),
  .release_o    (release_o)
);

// File: tb/sim_dispatch_sched.sv
`timescale 1ns/1ps
module sim_dispatch_sched;

  localparam int N  = 8;
  localparam int L  = 3;
  localparam int IW = 3;
  localparam int NP = 5;

  logic            clk;
  logic            rst_n;
  logic [L-1:0]    alloc_vld;
  logic [L*4-1:0]  alloc_cls;
  logic [L-1:0]    alloc_rdy;
  logic [L-1:0]    alloc_gnt;
  logic [L*IW-1:0] alloc_slot;
  logic [N-1:0]    wake;
  logic [NP-1:0]   port_free;
  logic [NP-1:0]   issue_vld;
  logic [NP*IW-1:0] issue_idx;
  logic [N-1:0]    release_m;

  dispatch_sched #(.N_ENTRY(N), .N_LANE(L)) u0 (
    .clk          (clk),
    .rst_n        (rst_n),
    .alloc_vld_i  (alloc_vld),
    .alloc_cls_i  (alloc_cls),
    .alloc_rdy_i  (alloc_rdy),
    .alloc_gnt_o  (alloc_gnt),
    .alloc_slot_o (alloc_slot),
    .wake_i       (wake),
    .port_free_i  (port_free),
    .issue_vld_o  (issue_vld),
    .issue_idx_o  (issue_idx),
    .release_o    (release_m)
  );

  initial clk = 1'b0;
  always #4 clk = ~clk;   // 125 MHz

  int  n_vec = 0;
  int  n_bad = 0;
  bit  done  = 0;

  // Bench model of the window
  bit m_vld [N];
  bit m_rdy [N];
  int m_cls [N];
  int m_seq [N];
  int seq_ctr = 0;

  task automatic chk(input string tag, input int act, input int exp);
    n_vec++;
    if (act != exp) begin
      n_bad++;
      $display("FAIL %s act=%0d exp=%0d t=%0t", tag, act, exp, $time);
    end
  endtask

  function automatic bit port_ok(input int c, input int p);
    case (p)
      0: return c >= 0 && c <= 4;
      1: return c == 0 || c == 5;
      2: return c == 6;
      3: return c == 7;
      default: return c == 8;
    endcase
  endfunction

  function automatic int pick(input int p, input logic [NP-1:0] pf, input int excl);
    int best;
    best = -1;
    if (!pf[p]) return -1;
    for (int i = 0; i < N; i++) begin
      if (m_vld[i] && m_rdy[i] && port_ok(m_cls[i], p) && i != excl) begin
        if (best < 0 || m_seq[i] < m_seq[best]) best = i;
      end
    end
    return best;
  endfunction

  task automatic idle_inputs();
    alloc_vld = '0; alloc_cls = '0; alloc_rdy = '0; wake = '0; port_free = '0;
  endtask

  // One cycle: drive at falling edge, check before the rising edge, advance model.
  task automatic step(input logic [L-1:0] av, input logic [L*4-1:0] ac, input logic [L-1:0] ar,
                      input logic [N-1:0] wk, input logic [NP-1:0] pf);
    int e [NP];
    int exp_rel;
    bit old_v [N];
    bit tk [N];
    int eg, es;
    alloc_vld = av; alloc_cls = ac; alloc_rdy = ar; wake = wk; port_free = pf;
    #2;
    e[0] = pick(0, pf, -1);
    e[1] = pick(1, pf, e[0]);
    for (int p = 2; p < NP; p++) e[p] = pick(p, pf, -1);
    exp_rel = 0;
    for (int p = 0; p < NP; p++) begin
      // R4 R5 R6 R7 R9: per-port issue and slot
      chk((p < 2) ? "R5 flex port issue" : "R4 fixed port issue",
          int'(issue_vld[p]), (e[p] >= 0) ? 1 : 0);
      if (e[p] >= 0) begin
        chk((p < 2) ? "R6 flex port oldest idx" : "R6 fixed port oldest idx",
            int'(issue_idx[p*IW +: IW]), e[p]);
        exp_rel = exp_rel | (1 << e[p]);
      end
    end
    // R8
    chk("R8 release mask", int'(release_m), exp_rel);
    old_v = m_vld;
    for (int i = 0; i < N; i++) tk[i] = 0;
    for (int k = 0; k < L; k++) begin
      eg = 0; es = 0;
      if (av[k]) begin
        for (int i = 0; i < N; i++) begin
          if (eg == 0 && !old_v[i] && !tk[i]) begin
            eg = 1; es = i; tk[i] = 1;
          end
        end
      end
      // R2
      chk("R2 lane grant", int'(alloc_gnt[k]), eg);
      if (eg == 1) chk("R2 lane slot", int'(alloc_slot[k*IW +: IW]), es);
    end
    for (int p = 0; p < NP; p++) if (e[p] >= 0) m_vld[e[p]] = 0;
    for (int i = 0; i < N; i++) if (old_v[i] && wk[i]) m_rdy[i] = 1;
    for (int k = 0; k < L; k++) begin
      if (av[k]) begin
        for (int i = 0; i < N; i++) begin
          if (!old_v[i] && tk[i] && !m_vld[i] && int'(alloc_slot[k*IW +: IW]) == i) begin
            m_vld[i] = 1; m_rdy[i] = ar[k]; m_cls[i] = int'(ac[k*4 +: 4]);
            m_seq[i] = seq_ctr; seq_ctr++;
          end
        end
      end
    end
    @(posedge clk);
    @(negedge clk);
  endtask

  task automatic do_reset();
    rst_n = 1'b0;
    idle_inputs();
    for (int i = 0; i < N; i++) m_vld[i] = 0;
    @(posedge clk);
    @(negedge clk);
    alloc_vld = '1;
    #1;
    // R1: nothing granted or issued during reset
    chk("R1 grant in reset", int'(alloc_gnt), 0);
    chk("R1 issue in reset", int'(issue_vld), 0);
    alloc_vld = '0;
    @(negedge clk);
    rst_n = 1'b1;
    @(posedge clk);
    @(posedge clk);
    @(negedge clk);
  endtask

  function automatic logic [11:0] cls3(input int c2, input int c1, input int c0);
    return {c2[3:0], c1[3:0], c0[3:0]};
  endfunction

  initial begin
    rst_n = 1'b1;
    idle_inputs();
    #1 rst_n = 1'b0;
    do_reset();

    // R2 R3 R6: lane 0 not ready, lanes 1 and 2 ready, all ALU
    step(3'b111, cls3(0, 0, 0), 3'b110, '0, 5'b11111);
    // R5: slot 1 on port 0, slot 2 on port 1; slot 0 blocked but younger ones proceed (R3)
    step('0, '0, '0, '0, 5'b11111);
    // R3: wake slot 0, visible next cycle
    step('0, '0, '0, 8'b0000_0001, 5'b11111);
    step('0, '0, '0, '0, 5'b11111);

    // R7: port 0 busy, ALU op goes to port 1
    step(3'b001, cls3(0, 0, 0), 3'b001, '0, 5'b00000);
    step('0, '0, '0, '0, 5'b11110);

    // R4: unknown class 12 stays; load, store-address, store-data go to ports 2..4
    step(3'b111, cls3(8, 7, 12), 3'b111, '0, 5'b00000);
    step(3'b001, cls3(0, 0, 6), 3'b001, '0, 5'b00000);
    step('0, '0, '0, '0, 5'b11111);

    // R2: fill with unknown class until lanes are refused
    for (int c = 0; c < 4; c++) step(3'b111, cls3(13, 14, 15), 3'b111, '0, 5'b11111);

    // R8: full window of loads; a released slot is not granted until the next cycle
    do_reset();
    step(3'b111, cls3(6, 6, 6), 3'b111, '0, 5'b00000);
    step(3'b111, cls3(6, 6, 6), 3'b111, '0, 5'b00000);
    step(3'b011, cls3(6, 6, 6), 3'b011, '0, 5'b00000);
    step(3'b001, cls3(6, 6, 6), 3'b001, '0, 5'b00100);
    step(3'b001, cls3(6, 6, 6), 3'b001, '0, 5'b00000);

    // Exhaustive: two class codes, a mixer lane, every port-free mask (R4 R5 R6 R7 R9)
    for (int a = 0; a < 16; a++) begin
      for (int b = 0; b < 16; b++) begin
        for (int pf = 0; pf < 32; pf++) begin
          do_reset();
          step(3'b111, cls3((a + b) % 9, b, a), 3'b111, '0, 5'b00000);
          step('0, '0, '0, '0, pf[4:0]);
          step('0, '0, '0, '0, 5'b11111);
        end
      end
    end

    // Random traffic with periodic resets (R2 R3 R5 R6 R8)
    do_reset();
    for (int n = 0; n < 20000; n++) begin
      logic [L-1:0]   av, ar;
      logic [L*4-1:0] ac;
      if (n % 50 == 49) do_reset();
      av = 3'($urandom);
      ar = 3'($urandom);
      for (int k = 0; k < L; k++) begin
        int c;
        c = ($urandom_range(0, 31) == 0) ? $urandom_range(9, 15) : $urandom_range(0, 8);
        ac[k*4 +: 4] = c[3:0];
      end
      step(av, ac, ar, 8'($urandom), 5'($urandom));
    end

    done = 1;
    $display("== %0d vectors applied, %0d miscompares ==", n_vec, n_bad);
    $finish;
  end

  initial begin
    repeat (190000) @(posedge clk);
    if (!done) begin
      n_bad++;
      $display("FAIL R1 watchdog act=running exp=finished");
      $display("== %0d vectors applied, %0d miscompares ==", n_vec, n_bad);
      $finish;
    end
  end

endmodule